// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block holds a 256-bit device secret and gives it to boot firmware over a simple register bus. The bus has a chip select, a write enable, an address and a 32-bit read-data output. The secret is split into eight 32-bit words at eight consecutive addresses. Firmware may fetch the words in any order. Each word gives its true value only on the first access after reset. After that, the word reads as zero until the next reset.

Each read-data bit comes from its own bit-slice: a small lookup of twice as many entries as there are words, so 16 entries by default. The lower half of a slice holds that bit of every word, and the upper half holds zeros. Each word has a sticky read flag. That flag drives the top address bit of every slice, so once a word has been read, any further lookup of it lands in the zero half. Reads are honoured only while the application-mode input is low, which means the CPU is still running boot firmware.

A small state machine controls the output. **IDLE** drives zero. **SERVE** presents the word captured at the previous edge. **BLOCKED** is entered whenever application mode is high and drives zero. Transitions:
- IDLE→SERVE, SERVE→SERVE and BLOCKED→SERVE on an accepted read (chip select high, write enable low, address in range, application mode low).
- SERVE→IDLE and BLOCKED→IDLE when no read is accepted and application mode is low.
- Any state→BLOCKED when application mode is high.

Top module: `secret_vault`

## Requirements
- R1: Word k (0 to 7) sits at address BASE_ADDR+k and equals SECRET[32k+31:32k]. An accepted read presents it on `rdata_o` one clock after the read cycle.
- R2: Words can be fetched in any order, and each word's first fetch returns its true value whatever was fetched before it.
- R3: A word's read flag is set by its first accepted read and stays set until reset. Every later read of that word returns zero.
- R4: While `app_mode_i` is high, every read returns zero and sets no read flag, so a later read of the same word with `app_mode_i` low still returns the true value.
- R5: If chip select is held high on one word over several cycles, `rdata_o` shows the true value for one cycle and zero in every following cycle.
- R6: A read to an address outside BASE_ADDR..BASE_ADDR+7 returns zero and sets no read flag.
- R7: A write cycle (`we_i` high) returns zero, does not change stored data and sets no read flag.
- R8: `rdata_o` is zero during reset and in every cycle that does not follow an accepted read.
- R9: Reset clears all read flags, so every word returns its true value again on its first read after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| app_mode_i | input | 1 | High when the CPU runs application code; blocks secret reads |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | Write enable (writes are ignored) |
| addr_i | input | ADDR_W | Word address |
| rdata_o | output | WORD_W | Registered read data |

## Verification
The bench first sweeps every out-of-range address, then every word in application mode, then writes to every word. It then confirms that each word still gives its true value. A design that let any of these cycles set a read flag would return zero on that word's first honest read. The words are fetched in a scrambled order and then fetched again. Unsticky flags would leak the secret on the second pass, and a wrong word index would give the wrong value on the first. After a reset, one word is held under chip select for several cycles to catch a design that lags the flag by an extra cycle. The remaining words are read after that reset to confirm that reset clears every flag.

// File: rtl/vault_pkg.sv
package vault_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVE   = 2'd1,
        ST_BLOCKED = 2'd2
    } vault_state_e;

endpackage

// File: rtl/vault_bitslice.sv
// One read-data bit: a lookup of 2*NUM_WORDS entries.
// Lower half holds bit BIT of each word, upper half is zero.
module vault_bitslice #(
    parameter int                          NUM_WORDS = 8,
    parameter int                          WORD_W    = 32,
    parameter int                          BIT       = 0,
    parameter logic [NUM_WORDS*WORD_W-1:0] SECRET    = '0,
    localparam int                         IDX_W     = $clog2(NUM_WORDS),
    localparam int                         DEPTH     = 2 * NUM_WORDS
) (
    input  logic [IDX_W:0] sel_i,
    output logic           bit_o
);

    function automatic logic [DEPTH-1:0] build_table();
        logic [DEPTH-1:0] t;
        t = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            t[w] = SECRET[w*WORD_W + BIT];
        end
        return t;
    endfunction

    localparam logic [DEPTH-1:0] CONTENT = build_table();

    assign bit_o = CONTENT[sel_i];

endmodule

// File: rtl/vault_flags.sv
// Sticky per-word read flags, cleared only by reset.
module vault_flags #(
    parameter  int NUM_WORDS = 8,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 set_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [NUM_WORDS-1:0] flags_o
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flag
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                flags_o[w] <= 1'b0;
            end else if (set_i && (idx_i == IDX_W'(w))) begin
                flags_o[w] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/secret_vault.sv
module secret_vault #(
    parameter int                          NUM_WORDS = 8,
    parameter int                          WORD_W    = 32,
    parameter int                          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]           BASE_ADDR = 8'h10,
    parameter logic [NUM_WORDS*WORD_W-1:0] SECRET    = {NUM_WORDS{32'h6C3A_91E5}}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              app_mode_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] rdata_o
);
    import vault_pkg::*;

    localparam int IDX_W = $clog2(NUM_WORDS);

    // Address decode
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic [IDX_W-1:0]  word_idx;
    logic              rd_go;

    assign offset   = addr_i - BASE_ADDR;
    assign in_range = (offset < ADDR_W'(NUM_WORDS));
    assign word_idx = offset[IDX_W-1:0];
    assign rd_go    = cs_i && !we_i && in_range && !app_mode_i;

    // Sticky read flags
    logic [NUM_WORDS-1:0] rd_flags;

    vault_flags #(.NUM_WORDS(NUM_WORDS)) flags_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (rd_go),
        .idx_i   (word_idx),
        .flags_o (rd_flags)
    );

    // Bit-sliced lookup; flag is the top select bit
    logic [IDX_W:0]    slice_sel;
    logic [WORD_W-1:0] lookup;

    assign slice_sel = {rd_flags[word_idx], word_idx};

    for (genvar b = 0; b < WORD_W; b++) begin : g_slice
        vault_bitslice #(
            .NUM_WORDS (NUM_WORDS),
            .WORD_W    (WORD_W),
            .BIT       (b),
            .SECRET    (SECRET)
        ) slice_i (
            .sel_i (slice_sel),
            .bit_o (lookup[b])
        );
    end

    // Control state machine
    vault_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_SERVE, ST_BLOCKED: begin
                if (app_mode_i)  state_d = ST_BLOCKED;
                else if (rd_go)  state_d = ST_SERVE;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Output process
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    word_q <= '0;
        else if (rd_go) word_q <= lookup;
        else            word_q <= '0;
    end

    assign rdata_o = (state_q == ST_SERVE) ? word_q : '0;

endmodule

// File: rtl/vault_chk.sv
module vault_chk #(
    parameter int                NUM_WORDS = 8,
    parameter int                WORD_W    = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 app_mode_i,
    input logic                 cs_i,
    input logic                 we_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [WORD_W-1:0]    rdata_o,
    input logic [NUM_WORDS-1:0] rd_flags
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    assign off = addr_i - BASE_ADDR;
    assign hit = (off < ADDR_W'(NUM_WORDS));
    assign idx = off[IDX_W-1:0];

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_flags & $past(rd_flags)) == $past(rd_flags))); // R3

    AST_REREAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_i && !we_i && hit && rd_flags[idx]) |=> (rdata_o == '0)); // R3

    AST_APP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        app_mode_i |=> (rdata_o == '0)); // R4

    AST_APP_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        app_mode_i |=> $stable(rd_flags)); // R4

    AST_RANGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> ($stable(rd_flags) && rdata_o == '0)); // R6

    AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> ($stable(rd_flags) && rdata_o == '0)); // R7

    AST_NO_CS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_i |=> (rdata_o == '0)); // R8

    AST_ONE_FLAG_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(rd_flags ^ $past(rd_flags)) <= 1)); // R3

endmodule

bind secret_vault vault_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .app_mode_i (app_mode_i),
    .cs_i       (cs_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .rd_flags   (rd_flags)
);

// File: tb/secret_vault_tb_top.sv
`timescale 1ns/1ps
module secret_vault_tb_top;

    localparam int         NW   = 8;
    localparam logic [7:0] BASE = 8'h10;

    function automatic logic [31:0] exp_word(input int k);
        return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'h1234_5678;
    endfunction

    function automatic logic [NW*32-1:0] mk_secret();
        logic [NW*32-1:0] s;
        for (int k = 0; k < NW; k++) s[k*32 +: 32] = exp_word(k);
        return s;
    endfunction

    localparam logic [NW*32-1:0] TB_SECRET = mk_secret();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        app = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    secret_vault #(
        .NUM_WORDS (NW), .WORD_W (32), .ADDR_W (8),
        .BASE_ADDR (BASE), .SECRET (TB_SECRET)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .app_mode_i (app),
        .cs_i (cs), .we_i (we), .addr_i (addr), .rdata_o (rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus cycle, sampled at the negedge after the capturing edge
    task automatic access(input logic w, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = w; addr = a;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset", rdata, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check("R8 reset", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle", rdata, 32'h0);

        // R6: every out-of-range address
        for (int a = 0; a < 256; a++) begin
            if (a < int'(BASE) || a >= int'(BASE) + NW) begin
                access(1'b0, 8'(a), d);
                check("R6 out of range", d, 32'h0);
            end
        end
        // R4: application mode blocks
        app = 1'b1;
        for (int k = 0; k < NW; k++) begin
            access(1'b0, BASE + 8'(k), d);
            check("R4 app mode", d, 32'h0);
        end
        app = 1'b0;
        // R7: writes ignored
        for (int k = 0; k < NW; k++) begin
            access(1'b1, BASE + 8'(k), d);
            check("R7 write", d, 32'h0);
        end
        @(negedge clk);
        check("R8 no access", rdata, 32'h0);

        // R1/R2: scrambled order first reads give true values
        for (int i = 0; i < NW; i++) begin
            int k;
            k = (i * 3 + 5) % NW;
            access(1'b0, BASE + 8'(k), d);
            check("R1 R2 first read", d, exp_word(k));
            @(negedge clk);
            check("R8 after read", rdata, 32'h0);
        end
        // R3: repeat reads are zero
        for (int k = 0; k < NW; k++) begin
            access(1'b0, BASE + 8'(k), d);
            check("R3 reread", d, 32'h0);
        end

        // R9 + R5: reset, then hold chip select on word 2
        do_reset();
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = BASE + 8'd2;
        @(negedge clk);
        check("R5 held first", rdata, exp_word(2));
        @(negedge clk);
        check("R5 held second", rdata, 32'h0);
        @(negedge clk);
        check("R5 held third", rdata, 32'h0);
        cs = 1'b0;
        for (int k = 0; k < NW; k++) begin
            access(1'b0, BASE + 8'(k), d);
            if (k == 2) check("R3 after hold", d, 32'h0);
            else        check("R9 after reset", d, exp_word(k));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule